// File: doc/BRIEF.md
# Host Interrupt Status and Control Register

This block is an eight-bit register that a host processor can read and write at any time while an embedded script sequencer keeps running. The host writes four control bits through it: an abort request, a soft reset that holds until it is cleared, a signal-process flag, and a semaphore that it shares with the sequencer. The host reads back a connected indication and three interrupt-pending images. Reads and writes have no side effects on the sequencer, apart from the control bits the host chooses to change.

The sequencer side has set and clear strobes for the semaphore. It also has a strobe that fires when the host reads a separate test/control register, which consumes the signal-process flag. A connect/disconnect event pair keeps the connected bit current. Three outputs leave the block: the abort request, the held soft reset, and a wait-jump signal. Wait-jump tells a pending wait-for-selection instruction to take its alternate address immediately.

The host port is a plain register port, with a single-cycle write strobe and a combinational read. It has no valid/ready handshake and no back-pressure: every write is accepted in the cycle it is presented, and read data is always valid. Bit positions, from MSB to LSB: abort 7, soft reset 6, signal-process 5, semaphore 4, connected 3, interrupt-on-the-fly 2, SCSI pending 1, DMA pending 0.

Top module: `hisc_top`

## Requirements
- R1: After hard reset (rst_n low), the register reads 00h and abort_req, soft_rst and wait_jump are low.
- R2: A host write with soft reset clear loads bit 7 from the written data. abort_req and read bit 7 show it on the next cycle.
- R3: A host write loads soft reset from bit 6. Soft reset then stays set on every cycle without a host write, until the host writes 0 to bit 6 or a hard reset occurs. soft_rst mirrors it.
- R4: While soft reset is held, abort, signal-process, semaphore and connected read 0 from the next cycle on. Host writes, sequencer semaphore sets and connect events cannot set them.
- R5: A host write loads signal-process from bit 5. Without a write, the aux-read strobe clears it. When the aux-read strobe and a write come in the same cycle, the written value wins: a written 1 stays set and a written 0 clears.
- R6: wait_jump is high in the same cycle that wait_pend is high and signal-process reads 1, and low otherwise.
- R7: The semaphore bit 4 is set by seq_sem_set or by a host write of 1, and cleared by seq_sem_clr or by a host write of 0. When a set and a clear source meet in one cycle, the set wins.
- R8: The connected bit 3 is set by conn_evt and cleared by disc_evt. If both arrive in one cycle, conn_evt wins. Host writes never change bit 3.
- R9: Bits 2, 1 and 0 read the current levels of fly_irq, scsi_irq and dma_irq, in the same cycle. Host writes to these bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current register value |
| aux_rd | input | 1 | Host read of the test/control register, consumes signal-process |
| seq_sem_set | input | 1 | Sequencer sets semaphore |
| seq_sem_clr | input | 1 | Sequencer clears semaphore |
| conn_evt | input | 1 | Connection established event |
| disc_evt | input | 1 | Disconnect event |
| fly_irq | input | 1 | Interrupt-on-the-fly pending level |
| scsi_irq | input | 1 | SCSI interrupt pending level |
| dma_irq | input | 1 | DMA interrupt pending level |
| wait_pend | input | 1 | A wait-for-selection instruction is waiting |
| abort_req | output | 1 | Abort request to the sequencer |
| soft_rst | output | 1 | Held soft reset to the operating logic |
| wait_jump | output | 1 | Take the alternate jump address now |

## Verification
The assertions assume that every strobe is a clean single-bit level that is sampled at the rising edge. They also assume that hard reset is the only thing that starts the register from a known state. The strobe checks apply only when soft reset is clear, because a held soft reset overrides the strobes. The bench drives every input on the falling edge, and it leaves soft reset clear before each semaphore, signal-process and connection sweep. Soft reset is entered only on purpose, inside the write sweep and the override tests.

// File: rtl/hisc_pkg.sv
package hisc_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic abort;
    logic srst;
    logic sigp;
    logic sem;
    logic conn;
    logic fly;
    logic scsi;
    logic dma;
  } hisc_reg_t;
endpackage

// File: rtl/hisc_ctl_bits.sv
module hisc_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_abort,
  input  logic wr_srst,
  input  logic wr_sigp,
  input  logic aux_rd,
  input  logic wait_pend,
  output logic abort_q,
  output logic srst_q,
  output logic sigp_q,
  output logic wait_jump
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      srst_q  <= 1'b0;
      sigp_q  <= 1'b0;
    end else begin
      if (wr_en) srst_q <= wr_srst;

      if (srst_q)     abort_q <= 1'b0;
      else if (wr_en) abort_q <= wr_abort;

      if (srst_q)      sigp_q <= 1'b0;
      else if (wr_en)  sigp_q <= wr_sigp;
      else if (aux_rd) sigp_q <= 1'b0;
    end
  end

  assign wait_jump = wait_pend & sigp_q;

  // R2
  abort_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst_q) |=> (abort_q == $past(wr_abort)));
  // R3
  srst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !wr_en) |=> srst_q);
  // R4
  srst_abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!abort_q && !sigp_q));
  // R5
  sigp_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_rd && !wr_en) |=> !sigp_q);
  // R6
  jump_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sigp && !srst_q) ##1 wait_pend |-> wait_jump);
endmodule

// File: rtl/hisc_sem_bit.sv
module hisc_sem_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic seq_set,
  input  logic seq_clr,
  input  logic wr_en,
  input  logic wr_val,
  output logic sem_q
);
  logic set_any, clr_any;

  assign set_any = seq_set | (wr_en & wr_val);
  assign clr_any = seq_clr | (wr_en & ~wr_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sem_q <= 1'b0;
    else if (srst)    sem_q <= 1'b0;
    else if (set_any) sem_q <= 1'b1;
    else if (clr_any) sem_q <= 1'b0;
  end

  // R7
  sem_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_set && !srst) |=> sem_q);
  // R7
  sem_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_clr && !seq_set && !wr_en) |=> !sem_q);
  // R4
  sem_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !sem_q);
endmodule

// File: rtl/hisc_conn_bit.sv
module hisc_conn_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic conn_evt,
  input  logic disc_evt,
  output logic conn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        conn_q <= 1'b0;
    else if (srst)     conn_q <= 1'b0;
    else if (conn_evt) conn_q <= 1'b1;
    else if (disc_evt) conn_q <= 1'b0;
  end

  // R8
  conn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_evt && !srst) |=> conn_q);
  // R8
  conn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_evt && !conn_evt) |=> !conn_q);
  // R8
  conn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conn_evt && !disc_evt && !srst) |=> (conn_q == $past(conn_q)));
endmodule

// File: rtl/hisc_top.sv
module hisc_top
  import hisc_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              aux_rd,
  input  logic              seq_sem_set,
  input  logic              seq_sem_clr,
  input  logic              conn_evt,
  input  logic              disc_evt,
  input  logic              fly_irq,
  input  logic              scsi_irq,
  input  logic              dma_irq,
  input  logic              wait_pend,
  output logic              abort_req,
  output logic              soft_rst,
  output logic              wait_jump
);
  hisc_reg_t wr_fields;
  hisc_reg_t rd_fields;
  logic abort_q, srst_q, sigp_q, sem_q, conn_q;

  assign wr_fields = hisc_reg_t'(host_wdata[REG_W-1:0]);

  hisc_ctl_bits u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr),
    .wr_abort  (wr_fields.abort),
    .wr_srst   (wr_fields.srst),
    .wr_sigp   (wr_fields.sigp),
    .aux_rd    (aux_rd),
    .wait_pend (wait_pend),
    .abort_q   (abort_q),
    .srst_q    (srst_q),
    .sigp_q    (sigp_q),
    .wait_jump (wait_jump)
  );

  hisc_sem_bit u_sem (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_q),
    .seq_set (seq_sem_set),
    .seq_clr (seq_sem_clr),
    .wr_en   (host_wr),
    .wr_val  (wr_fields.sem),
    .sem_q   (sem_q)
  );

  hisc_conn_bit u_conn (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst_q),
    .conn_evt (conn_evt),
    .disc_evt (disc_evt),
    .conn_q   (conn_q)
  );

  always_comb begin
    rd_fields       = '0;
    rd_fields.abort = abort_q;
    rd_fields.srst  = srst_q;
    rd_fields.sigp  = sigp_q;
    rd_fields.sem   = sem_q;
    rd_fields.conn  = conn_q;
    rd_fields.fly   = fly_irq;
    rd_fields.scsi  = scsi_irq;
    rd_fields.dma   = dma_irq;
  end

  generate
    if (DATA_W > REG_W) begin : g_pad
      assign host_rdata = {{(DATA_W-REG_W){1'b0}}, rd_fields};
    end else begin : g_exact
      assign host_rdata = rd_fields;
    end
  endgenerate

  assign abort_req = abort_q;
  assign soft_rst  = srst_q;

  // R3
  srst_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[6]) |=> soft_rst);
  // R8
  conn_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !conn_evt && !disc_evt && !soft_rst) |=> (host_rdata[3] == $past(host_rdata[3])));
endmodule

// File: tb/hisc_top_bench.sv
module hisc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       aux_rd = 1'b0, seq_sem_set = 1'b0, seq_sem_clr = 1'b0;
  logic       conn_evt = 1'b0, disc_evt = 1'b0;
  logic       fly_irq = 1'b0, scsi_irq = 1'b0, dma_irq = 1'b0, wait_pend = 1'b0;
  logic       abort_req, soft_rst, wait_jump;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hisc_top u_hisc_top (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .aux_rd(aux_rd), .seq_sem_set(seq_sem_set),
    .seq_sem_clr(seq_sem_clr), .conn_evt(conn_evt), .disc_evt(disc_evt),
    .fly_irq(fly_irq), .scsi_irq(scsi_irq), .dma_irq(dma_irq),
    .wait_pend(wait_pend), .abort_req(abort_req), .soft_rst(soft_rst),
    .wait_jump(wait_jump)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v;
    cyc();
    host_wr = 1'b0; host_wdata = 8'h00;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk("R1", host_rdata, 8'h00);
    chk("R1", {5'b0, abort_req, soft_rst, wait_jump}, 8'h00);
    rst_n = 1'b1;
    cyc();
    chk("R1", host_rdata, 8'h00);

    // R2 R3 R4: sweep every write value from a clean state
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w, e1;
      w = v[7:0];
      hwrite(8'h00);
      hwrite(w);
      e1 = w & 8'hF0;
      chk("R2", host_rdata, e1);
      chk("R2", {7'b0, abort_req}, {7'b0, w[7]});
      chk("R3", {7'b0, soft_rst}, {7'b0, w[6]});
      cyc(); cyc();
      chk("R4", host_rdata, w[6] ? 8'h40 : e1);
    end
    hwrite(8'h00);
    chk("R3", host_rdata, 8'h00);

    // R7 semaphore: every combination of sources and start value
    for (int i = 0; i < 32; i++) begin
      logic [4:0] b;
      logic st, cl, ex;
      b = i[4:0];
      hwrite(b[0] ? 8'h10 : 8'h00);
      seq_sem_set = b[1]; seq_sem_clr = b[2];
      host_wr = b[3]; host_wdata = b[4] ? 8'h10 : 8'h00;
      cyc();
      seq_sem_set = 0; seq_sem_clr = 0; host_wr = 0; host_wdata = 0;
      st = b[1] | (b[3] & b[4]);
      cl = b[2] | (b[3] & ~b[4]);
      ex = st ? 1'b1 : (cl ? 1'b0 : b[0]);
      chk("R7", {7'b0, host_rdata[4]}, {7'b0, ex});
    end
    hwrite(8'h00);

    // R5 R6 signal-process against aux read and write
    for (int i = 0; i < 16; i++) begin
      logic [3:0] b;
      logic ex;
      b = i[3:0];
      hwrite(b[0] ? 8'h20 : 8'h00);
      aux_rd = b[1]; host_wr = b[2]; host_wdata = b[3] ? 8'h20 : 8'h00;
      cyc();
      aux_rd = 0; host_wr = 0; host_wdata = 0;
      ex = b[2] ? b[3] : (b[1] ? 1'b0 : b[0]);
      chk("R5", {7'b0, host_rdata[5]}, {7'b0, ex});
      wait_pend = 1'b0;
      #1 chk("R6", {7'b0, wait_jump}, 8'h00);
      wait_pend = 1'b1;
      #1 chk("R6", {7'b0, wait_jump}, {7'b0, ex});
      wait_pend = 1'b0;
    end
    hwrite(8'h00);

    // R8 connected bit
    for (int i = 0; i < 8; i++) begin
      logic [2:0] b;
      logic ex;
      b = i[2:0];
      if (b[0]) conn_evt = 1'b1; else disc_evt = 1'b1;
      cyc();
      conn_evt = b[1]; disc_evt = b[2];
      cyc();
      conn_evt = 0; disc_evt = 0;
      ex = b[1] ? 1'b1 : (b[2] ? 1'b0 : b[0]);
      chk("R8", {7'b0, host_rdata[3]}, {7'b0, ex});
      hwrite(ex ? 8'h00 : 8'h08);
      chk("R8 write ignored", {7'b0, host_rdata[3]}, {7'b0, ex});
    end
    disc_evt = 1'b1; cyc(); disc_evt = 1'b0;

    // R9 input images, writes ignored
    for (int j = 0; j < 8; j++) begin
      logic [2:0] b;
      b = j[2:0];
      fly_irq = b[2]; scsi_irq = b[1]; dma_irq = b[0];
      #1 chk("R9", host_rdata & 8'h07, {5'b0, b});
      hwrite({5'b0, ~b});
      chk("R9", host_rdata & 8'h07, {5'b0, b});
    end
    fly_irq = 0; scsi_irq = 0; dma_irq = 0;

    // R4 sets blocked while soft reset held; R3 held over idle cycles
    conn_evt = 1'b1; cyc(); conn_evt = 1'b0;
    hwrite(8'h78);
    cyc();
    chk("R4", host_rdata, 8'h40);
    seq_sem_set = 1'b1; conn_evt = 1'b1; host_wr = 1'b1; host_wdata = 8'hF0;
    cyc();
    seq_sem_set = 0; conn_evt = 0; host_wr = 0; host_wdata = 0;
    cyc(); cyc(); cyc();
    chk("R4", host_rdata, 8'h40);
    chk("R3", {7'b0, soft_rst}, 8'h01);
    hwrite(8'h00);
    chk("R3", host_rdata, 8'h00);

    // R1 hard reset clears a held soft reset
    hwrite(8'h40);
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    chk("R1", host_rdata, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule